// File: doc/BRIEF.md
# I2C Read Target with Software-Held Address Acknowledge

This block is the target side of an I2C link with 7-bit addressing, built for read transfers. It watches SCL and SDA, which arrive already synchronised to the system clock. Its pin outputs are open-drain enables: a 1 pulls the line low. It detects Start and Stop conditions and shifts in the address byte. When the seven address bits equal the programmed address and the direction bit asks for a read, it acknowledges and streams data bytes out to the bus controller.

With address hold switched on, the block stops after the eighth falling SCL edge of a matching address. It holds SCL low before any acknowledge appears on the bus, raises the interrupt flag and waits. Software reads the address, picks ACK or NACK through a configuration bit and pulses the release input. After every acknowledged byte, including the address, the block holds SCL again until software supplies the next byte and releases the clock. A NACK from the controller ends the transfer without further stretching.

The received address leaves through a valid/ready output. The rules for back-pressure there are as follows. `rx_valid` stays high and `rx_data` stays stable until a cycle with `rx_ready` high. A new address overwrites an unread one. Bytes to send enter through a valid/ready input. `tx_ready` is high only while the block holds SCL after an acknowledge and its one-byte buffer is empty. A byte is taken in a cycle with both `tx_valid` and `tx_ready` high. The source may hold `tx_valid` high for as long as it likes.

Top module: `i2ct_target`

## Requirements
- R1: A Start (SDA falls while SCL is high) sets `st_start` and clears `st_stop`. It raises `irq` only when `cfg_start_ie` is 1.
- R2: A Stop (SDA rises while SCL is high) sets `st_stop`, clears `st_start`, returns the block to idle, releases both lines and leaves `clk_rel` at 1.
- R3: The first byte after a Start is shifted in MSB first: seven address bits, then the direction bit, where 1 means read. If bits 7..1 equal `cfg_own_addr` and bit 0 is 1, the byte is offered on `rx_data` with `rx_valid` high, and `rx_ready` removes it. For any other address or for a write, the block leaves SDA released on the ninth pulse, raises no `irq` and offers nothing.
- R4: With `cfg_hold_en` at 1, the eighth falling SCL edge of a matching address clears `clk_rel`, holds SCL low and raises `irq`. In the same edge `st_acktim` goes to 1, `st_data` to 0 and `st_rw` to 1.
- R5: The ninth address pulse carries `cfg_ack_nack`: 0 pulls SDA low (ACK) and 1 leaves it released (NACK). In hold mode the value is taken when `rel_set` is pulsed, and that pulse releases SCL.
- R6: After an address ACK, and after each data byte the controller ACKs, the block clears `clk_rel`, raises `irq` and holds SCL low. The hold lasts until a byte has been loaded and `clk_rel` is set again. `tx_ready` is 0 during the address acknowledge phase.
- R7: Loading a byte sets `buf_full`. The byte goes out MSB first. SDA changes only while SCL is low, and SDA is released after the eighth bit.
- R8: The SDA level the controller presents at the ninth rising SCL edge of a data byte is stored in `st_ackstat` (0 = ACK). `st_data` is 1 after a data byte has been sent.
- R9: After a controller NACK, the block holds neither line and raises no `irq`.
- R10: `irq` stays at 1 until `irq_clr` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| cfg_own_addr | input | ADDR_W | Programmed 7-bit address |
| cfg_hold_en | input | 1 | Stretch SCL before the address acknowledge |
| cfg_start_ie | input | 1 | Raise `irq` on a Start |
| cfg_ack_nack | input | 1 | Address acknowledge value (0 = ACK) |
| rel_set | input | 1 | Pulse: set `clk_rel` |
| irq_clr | input | 1 | Pulse: clear `irq` |
| rx_data | output | DATA_W | Received address byte |
| rx_valid | output | 1 | Address byte waiting |
| rx_ready | input | 1 | Consumer takes the address byte |
| tx_data | input | DATA_W | Byte to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Block accepts a byte |
| clk_rel | output | 1 | Clock release bit (0 = block stretching) |
| buf_full | output | 1 | Receive or transmit buffer occupied |
| irq | output | 1 | Interrupt flag |
| st_start | output | 1 | Start seen since the last Stop |
| st_stop | output | 1 | Stop seen since the last Start |
| st_rw | output | 1 | Direction bit of the last matching address |
| st_data | output | 1 | Last byte handled was data (0 = address) |
| st_acktim | output | 1 | Address acknowledge phase in progress |
| st_ackstat | output | 1 | Controller acknowledge of the last sent byte |

## Verification
Transfers run with address hold both on and off. Comparing the two shows whether stretching happens before the acknowledge or only after it. In hold mode, software answers with ACK on some transfers and NACK on others, which shows whether the ninth pulse follows the configuration bit. Addresses that match, addresses that differ and matching addresses with the write bit set tell a true hit apart from a near miss. Reads of one to four bytes, each ending with a controller NACK, exercise the repeated hold-load-release loop and the final release without stretching. Starts with the interrupt enabled and disabled separate the status bit from the interrupt.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_AHOLD,
    S_AACK,
    S_THOLD,
    S_TBITS,
    S_TACK,
    S_WAIT
  } i2ct_state_e;
endpackage

// File: rtl/i2ct_edges.sv
module i2ct_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i && !scl_q;
  assign scl_fall  = !scl_i && scl_q;
  // SDA transitions are only conditions when SCL stays high across them
  assign start_det = scl_i && scl_q && sda_q && !sda_i;
  assign stop_det  = scl_i && scl_q && !sda_q && sda_i;
endmodule

// File: rtl/i2ct_flags.sv
module i2ct_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic start_det,
  input  logic stop_det,
  input  logic ev_irq,
  input  logic cfg_start_ie,
  input  logic irq_clr,
  output logic irq,
  output logic st_start,
  output logic st_stop
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq      <= 1'b0;
      st_start <= 1'b0;
      st_stop  <= 1'b0;
    end else begin
      if (start_det) begin
        st_start <= 1'b1;
        st_stop  <= 1'b0;
      end else if (stop_det) begin
        st_stop  <= 1'b1;
        st_start <= 1'b0;
      end
      // setting events win over a clear in the same cycle
      if (ev_irq || (start_det && cfg_start_ie)) irq <= 1'b1;
      else if (irq_clr)                          irq <= 1'b0;
    end
  end
endmodule

// File: rtl/i2ct_ctrl.sv
module i2ct_ctrl
  import i2ct_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = DATA_W - 1,
  localparam int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_i,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] cfg_own_addr,
  input  logic              cfg_hold_en,
  input  logic              cfg_ack_nack,
  input  logic              rel_set,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              clk_rel,
  output logic              ev_irq,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_full,
  output logic              st_rw,
  output logic              st_data,
  output logic              st_acktim,
  output logic              st_ackstat
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  i2ct_state_e       state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rx_sh, tx_sh;
  logic              sda_drv;

  logic addr_done, addr_hit, aack_done, tack_done, rel_now;

  assign addr_done = (state == S_ADDR) && scl_fall && (cnt == CNT_FULL);
  assign addr_hit  = (rx_sh[DATA_W-1:1] == cfg_own_addr) && rx_sh[0];
  assign aack_done = (state == S_AACK) && scl_fall;
  assign tack_done = (state == S_TACK) && scl_fall;
  assign rel_now   = clk_rel || rel_set;

  assign ev_irq = !start_det && !stop_det &&
                  ((addr_done && addr_hit && cfg_hold_en) ||
                   (aack_done && sda_drv) ||
                   (tack_done && !st_ackstat));

  assign scl_oe   = (state == S_AHOLD) || (state == S_THOLD);
  assign sda_oe   = sda_drv;
  assign tx_ready = (state == S_THOLD) && !tx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      sda_drv    <= 1'b0;
      clk_rel    <= 1'b1;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      tx_full    <= 1'b0;
      st_rw      <= 1'b0;
      st_data    <= 1'b0;
      st_acktim  <= 1'b0;
      st_ackstat <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (tx_valid && tx_ready) begin
        tx_sh   <= tx_data;
        tx_full <= 1'b1;
      end

      if (stop_det || start_det) begin
        state      <= start_det ? S_ADDR : S_IDLE;
        cnt        <= '0;
        sda_drv    <= 1'b0;
        clk_rel    <= 1'b1;
        tx_full    <= 1'b0;
        st_acktim  <= 1'b0;
        st_ackstat <= 1'b0;
      end else begin
        unique case (state)
          S_ADDR: begin
            if (scl_rise && cnt != CNT_FULL) begin
              rx_sh <= {rx_sh[DATA_W-2:0], sda_i};
              cnt   <= cnt + 1'b1;
            end
            if (addr_done) begin
              cnt <= '0;
              if (addr_hit) begin
                rx_data   <= rx_sh;
                rx_valid  <= 1'b1;
                st_rw     <= rx_sh[0];
                st_data   <= 1'b0;
                st_acktim <= 1'b1;
                if (cfg_hold_en) begin
                  clk_rel <= 1'b0;
                  state   <= S_AHOLD;
                end else begin
                  sda_drv <= !cfg_ack_nack;
                  state   <= S_AACK;
                end
              end else begin
                state <= S_WAIT;
              end
            end
          end
          S_AHOLD: begin
            if (rel_set) begin
              clk_rel <= 1'b1;
              sda_drv <= !cfg_ack_nack;
              state   <= S_AACK;
            end
          end
          S_AACK: begin
            if (aack_done) begin
              st_acktim <= 1'b0;
              sda_drv   <= 1'b0;
              if (sda_drv) begin
                clk_rel <= 1'b0;
                state   <= S_THOLD;
              end else begin
                state <= S_WAIT;
              end
            end
          end
          S_THOLD: begin
            if (rel_set) clk_rel <= 1'b1;
            if (rel_now && tx_full) begin
              sda_drv <= !tx_sh[DATA_W-1];
              cnt     <= '0;
              state   <= S_TBITS;
            end
          end
          S_TBITS: begin
            if (scl_fall) begin
              if (cnt == CNT_LAST) begin
                sda_drv <= 1'b0;
                cnt     <= '0;
                tx_full <= 1'b0;
                st_data <= 1'b1;
                state   <= S_TACK;
              end else begin
                tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
                sda_drv <= !tx_sh[DATA_W-2];
                cnt     <= cnt + 1'b1;
              end
            end
          end
          S_TACK: begin
            if (scl_rise) st_ackstat <= sda_i;
            if (tack_done) begin
              if (!st_ackstat) begin
                clk_rel <= 1'b0;
                state   <= S_THOLD;
              end else begin
                state <= S_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2ct_target.sv
module i2ct_target #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] cfg_own_addr,
  input  logic              cfg_hold_en,
  input  logic              cfg_start_ie,
  input  logic              cfg_ack_nack,
  input  logic              rel_set,
  input  logic              irq_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              clk_rel,
  output logic              buf_full,
  output logic              irq,
  output logic              st_start,
  output logic              st_stop,
  output logic              st_rw,
  output logic              st_data,
  output logic              st_acktim,
  output logic              st_ackstat
);
  logic scl_rise, scl_fall, start_det, stop_det, ev_irq, tx_full;

  i2ct_edges u_edges (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2ct_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .cfg_own_addr(cfg_own_addr), .cfg_hold_en(cfg_hold_en),
    .cfg_ack_nack(cfg_ack_nack), .rel_set(rel_set),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .clk_rel(clk_rel), .ev_irq(ev_irq),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_full(tx_full), .st_rw(st_rw), .st_data(st_data),
    .st_acktim(st_acktim), .st_ackstat(st_ackstat)
  );

  i2ct_flags u_flags (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
    .ev_irq(ev_irq), .cfg_start_ie(cfg_start_ie), .irq_clr(irq_clr),
    .irq(irq), .st_start(st_start), .st_stop(st_stop)
  );

  assign buf_full = rx_valid || tx_full;
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic scl_oe,
  input logic sda_oe,
  input logic clk_rel,
  input logic irq,
  input logic irq_clr,
  input logic cfg_start_ie,
  input logic st_start,
  input logic st_ackstat,
  input logic st_acktim,
  input logic st_data,
  input logic tx_valid,
  input logic tx_ready,
  input logic buf_full
);
  AST_START_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_start) && $past(cfg_start_ie) |-> irq);                        // R1
  AST_HOLD_WHILE_NOT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_rel |-> scl_oe);                                                    // R4
  AST_ACKTIM_IS_ADDRESS: assert property (@(posedge clk) disable iff (!rst_n)
    st_acktim |-> !st_data);                                                 // R4
  AST_NO_LOAD_IN_ACKTIM: assert property (@(posedge clk) disable iff (!rst_n)
    st_acktim |-> !tx_ready);                                                // R6
  AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> buf_full);                                      // R7
  AST_SDA_STILL_WHILE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    scl_i && $past(scl_i) |-> $stable(sda_oe));                              // R7
  AST_NACK_NO_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    st_ackstat |-> !scl_oe);                                                 // R9
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);                                                // R10
endmodule

bind i2ct_target i2ct_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .clk_rel(clk_rel), .irq(irq), .irq_clr(irq_clr), .cfg_start_ie(cfg_start_ie),
  .st_start(st_start), .st_ackstat(st_ackstat), .st_acktim(st_acktim),
  .st_data(st_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .buf_full(buf_full)
);

// File: tb/tb_i2ct_target.sv
module tb_i2ct_target;
  localparam int DW = 8;
  localparam int AW = DW - 1;
  localparam int Q  = 6;
  localparam logic [AW-1:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_i, sda_i, scl_oe, sda_oe;
  assign scl_i = m_scl & ~scl_oe;
  assign sda_i = m_sda & ~sda_oe;

  logic [AW-1:0] cfg_own_addr = OWN;
  logic cfg_hold_en = 0, cfg_start_ie = 0, cfg_ack_nack = 0;
  logic rel_set = 0, irq_clr = 0, rx_ready = 0, tx_valid = 0;
  logic [DW-1:0] tx_data = '0;
  logic [DW-1:0] rx_data;
  logic rx_valid, tx_ready, clk_rel, buf_full, irq;
  logic st_start, st_stop, st_rw, st_data, st_acktim, st_ackstat;

  i2ct_target #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .cfg_own_addr(cfg_own_addr),
    .cfg_hold_en(cfg_hold_en), .cfg_start_ie(cfg_start_ie),
    .cfg_ack_nack(cfg_ack_nack), .rel_set(rel_set), .irq_clr(irq_clr),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .clk_rel(clk_rel), .buf_full(buf_full), .irq(irq),
    .st_start(st_start), .st_stop(st_stop), .st_rw(st_rw),
    .st_data(st_data), .st_acktim(st_acktim), .st_ackstat(st_ackstat)
  );

  int n_run = 0, n_fail = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_hit(input logic [AW-1:0] a, input bit rw);
    return (a == OWN) && rw;
  endfunction

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask
  task automatic scl_up();
    m_scl = 1'b1;
    while (!scl_i) @(negedge clk);
  endtask
  task automatic c_start();
    m_sda = 1; m_scl = 1; qwait(); m_sda = 0; qwait(); m_scl = 0; qwait();
  endtask
  task automatic c_stop();
    m_sda = 0; qwait(); scl_up(); qwait(); m_sda = 1; qwait();
  endtask
  task automatic c_wbit(input bit b);
    m_sda = b; qwait(); scl_up(); qwait(); qwait(); m_scl = 0; qwait();
  endtask
  task automatic c_rbit(output bit b);
    m_sda = 1; qwait(); scl_up(); qwait(); b = sda_i; qwait(); m_scl = 0; qwait();
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
  endtask
  task automatic pulse_rel();
    @(negedge clk); rel_set = 1; @(negedge clk); rel_set = 0;
  endtask
  task automatic pop_rx();
    @(negedge clk); rx_ready = 1; @(negedge clk); rx_ready = 0;
  endtask

  task automatic xfer(input logic [AW-1:0] a, input bit rw, input bit hold,
                      input bit swnack, input int nb);
    logic [DW-1:0] data [4];
    bit hit, ack;
    hit = exp_hit(a, rw);
    ack = hit && !swnack;
    for (int k = 0; k < 4; k++) data[k] = DW'($urandom);
    cfg_hold_en  = hold;
    cfg_ack_nack = hold ? 1'b0 : swnack;
    fork
      begin
        bit b;
        logic [DW-1:0] got;
        c_start();
        for (int i = AW - 1; i >= 0; i--) c_wbit(a[i]);
        c_wbit(rw);
        c_rbit(b);
        chk("R5 address acknowledge level (R3 match)", b, ack ? 0 : 1);
        if (!b) begin
          for (int k = 0; k < nb; k++) begin
            got = '0;
            for (int i = 0; i < DW; i++) begin
              bit bb;
              c_rbit(bb);
              got = {got[DW-2:0], bb};
            end
            chk("R7 byte sent MSB first", got, data[k]);
            c_wbit(k == nb - 1);
          end
          qwait();
          chk("R8 NACK stored in st_ackstat", st_ackstat, 1);
          chk("R9 SCL not held after NACK", scl_oe, 0);
          chk("R9 SDA released after NACK", sda_oe, 0);
          chk("R9 no irq after NACK", irq, 0);
        end
        c_stop();
        chk("R2 st_stop after Stop", st_stop, 1);
        chk("R2 st_start cleared by Stop", st_start, 0);
        chk("R2 clk_rel set after Stop", clk_rel, 1);
      end
      begin
        if (hold && hit) begin
          wait (irq);
          @(negedge clk);
          chk("R4 clk_rel cleared on hold", clk_rel, 0);
          chk("R4 SCL held before ACK", scl_oe, 1);
          chk("R4 st_acktim set", st_acktim, 1);
          chk("R4 st_data shows address", st_data, 0);
          chk("R4 st_rw read", st_rw, 1);
          chk("R6 no load during acknowledge phase", tx_ready, 0);
          chk("R3 address offered", rx_valid, 1);
          chk("R3 address byte", rx_data, {a, 1'b1});
          pop_rx();
          chk("R3 pop clears rx_valid", rx_valid, 0);
          cfg_ack_nack = swnack;
          pulse_clr();
          pulse_rel();
        end
        if (ack) begin
          for (int k = 0; k < nb; k++) begin
            wait (irq);
            @(negedge clk);
            chk("R6 hold after ACK", scl_oe && !clk_rel, 1);
            chk("R8 st_data after byte", st_data, k > 0);
            if (k > 0) chk("R8 ACK stored in st_ackstat", st_ackstat, 0);
            if (!hold && k == 0) begin
              chk("R3 address offered without hold", rx_data, {a, 1'b1});
              pop_rx();
            end
            pulse_clr();
            @(negedge clk);
            tx_valid = 1; tx_data = data[k];
            while (!tx_ready) @(negedge clk);
            @(negedge clk);
            tx_valid = 0;
            chk("R7 load sets buf_full", buf_full, 1);
            chk("R6 still held until release", scl_oe, 1);
            pulse_rel();
          end
        end
      end
    join
    if (!hit) begin
      chk("R3 no address offered on miss", rx_valid, 0);
      chk("R3 no irq on miss", irq, 0);
    end
    if (rx_valid) pop_rx();
    if (irq) pulse_clr();
    qwait();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2 reset SCL released", scl_oe, 0);
    chk("R2 reset SDA released", sda_oe, 0);
    chk("R2 reset clk_rel", clk_rel, 1);
    chk("R10 reset irq", irq, 0);
    chk("R7 reset buf_full", buf_full, 0);

    cfg_start_ie = 1;
    c_start();
    chk("R1 st_start set", st_start, 1);
    chk("R1 irq on Start with enable", irq, 1);
    repeat (20) @(negedge clk);
    chk("R10 irq held without clear", irq, 1);
    pulse_clr();
    chk("R10 irq cleared", irq, 0);
    c_stop();
    chk("R2 st_stop set", st_stop, 1);
    cfg_start_ie = 0;
    c_start();
    chk("R1 st_start without enable", st_start, 1);
    chk("R1 st_stop cleared by Start", st_stop, 0);
    chk("R1 no irq with enable off", irq, 0);
    c_stop();

    xfer(OWN, 1, 1, 0, 3);
    xfer(OWN, 1, 1, 1, 2);
    xfer(OWN, 1, 0, 0, 2);
    xfer(OWN, 0, 1, 0, 1);
    xfer(OWN ^ 7'h01, 1, 1, 0, 1);
    xfer(OWN, 1, 0, 0, 1);

    for (int t = 0; t < 14; t++) begin
      logic [AW-1:0] a;
      a = ($urandom % 3 == 0) ? AW'($urandom) : OWN;
      xfer(a, ($urandom % 5) != 0, $urandom % 2, ($urandom % 6) == 0,
           1 + ($urandom % 4));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule